// File: doc/BRIEF.md
# I/O Window Mixed-Address Select and Joypad Strobe

This block decodes reads of a 32-byte on-chip I/O register window while a DMA engine has stalled the CPU core. During such a stall the core keeps presenting the address of the read it was halted on, and it repeats that read on every DMA cycle that performs no access. The register select is formed from two sources. The window match uses the upper address bits of the frozen core address. The register offset inside the window comes from the low bits of the external bus, which the DMA engine drives on its own access cycles. So a DMA fetch from ordinary memory can select a different I/O register than the one the core was reading.

From that mixed select the block produces a one-hot register select, two active-low joypad output enables, and one clock-event pulse per joypad port. It also produces a bus-conflict flag and a status-override flag. In the default mode a joypad sees one clock event per contiguous run of cycles that read it. In the alternate mode the enable is treated as gated to half of each cycle, so every read cycle counts as an event. The contents of the registers are outside this block.

Top module: `io_window_select`

## Requirements
- R1: When `rd` is high and `core_addr[15:5]` equals the window base bits (default 0x4000 >> 5), exactly one bit of `reg_sel` is high, at index `bus_addr[4:0]`. The low bits of the core address play no part.
- R2: When `core_addr` lies outside the window, `reg_sel` is all zero, both `pad_oe_n` bits are high, and `pad_clk`, `bus_conflict` and `stat_override` are low, whatever `bus_addr` holds.
- R3: When `rd` is low, nothing is selected, both `pad_oe_n` bits are high, and no clock event is produced.
- R4: `pad_oe_n[0]` is low exactly when offset 0x16 is selected, and `pad_oe_n[1]` is low exactly when offset 0x17 is selected.
- R5: With `pad_mode` = 0 (run mode), `pad_clk[i]` is high for one cycle only, on the first cycle of each unbroken run of cycles that select port i. A cycle that does not select the port ends the run.
- R6: With `pad_mode` = 1 (every-read mode), `pad_clk[i]` is high on every cycle that selects port i.
- R7: `bus_conflict` is high when `dma_active` and `rd` are high, a readable register is selected (offsets 0x15, 0x16, 0x17), and `bus_addr[15:5]` lies outside the window. It is low when the DMA address itself lies inside the window.
- R8: `stat_override` is high exactly when the status register at offset 0x15 is selected.
- R9: A core frozen on port 0 (0x4016) with a DMA address whose low bits are 0x17 selects port 1. That asserts `pad_oe_n[1]` low, produces a `pad_clk[1]` event, and leaves port 0 unselected.
- R10: During reset (`rst_n` low at a clock edge) the run history is cleared. With reset held and `rd` low, all outputs are idle. The first selecting read after reset produces an event in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | synchronous active-low reset |
| core_addr | input | 16 | address held by the (possibly stalled) core |
| bus_addr | input | 16 | address on the external bus (DMA address on DMA access cycles) |
| rd | input | 1 | current cycle is a read cycle |
| dma_active | input | 1 | the DMA engine owns the bus for an access this cycle |
| pad_mode | input | 1 | 0: one event per read run, 1: one event per read cycle |
| reg_sel | output | 32 | one-hot select of the I/O register window |
| pad_oe_n | output | 2 | active-low joypad output enables |
| pad_clk | output | 2 | joypad clock-event pulse per port |
| bus_conflict | output | 1 | internal register drives while the DMA reads external memory |
| stat_override | output | 1 | internal status value replaces external data |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, a 32-register window at 0x4000, the status register at offset 0x15, and two joypad ports at 0x16 and 0x17. Because the two ports sit next to each other, a DMA address that differs by one in its low bits moves the select from one port to the other. That makes the cross-port clock event and the conflict case reachable with single-cycle stimulus. The bench also runs stall sequences with repeated core reads broken by DMA fetches. These show run mode restarting its count, and every-read mode counting each cycle. Addresses just below and just above the window are included.

// File: rtl/io_win_pkg.sv
// io_win_pkg: shared defaults and mode encoding for the I/O window select.
// Assumes a power-of-two register window addressed by the low offset bits.
package io_win_pkg;
    localparam int unsigned ADDR_W_DEF   = 16;
    localparam int unsigned OFS_W_DEF    = 5;
    localparam int unsigned N_PAD_DEF    = 2;
    localparam int unsigned STAT_OFS_DEF = 21;  // 0x15
    localparam int unsigned PAD_BASE_DEF = 22;  // 0x16, ports follow upward

    // Joypad event counting mode
    typedef enum logic {
        PAD_MODE_RUN   = 1'b0,
        PAD_MODE_EVERY = 1'b1
    } pad_mode_e;
endpackage

// File: rtl/io_win_decode.sv
// io_win_decode: forms the mixed register address and the one-hot select.
// The window match takes the upper bits of the core address and the offset
// takes the low bits of the bus address. Purely combinational.
module io_win_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned OFS_W    = 5,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
    input  logic [ADDR_W-1:0]      core_addr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   rd,
    output logic [(1<<OFS_W)-1:0]  reg_sel,
    output logic                   bus_in_win
);
    localparam int unsigned N_REG = 1 << OFS_W;
    localparam logic [ADDR_W-OFS_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFS_W];

    logic             core_in_win;
    logic [OFS_W-1:0] mix_ofs;
    logic             unused_core_low;

    // window match on core bits, offset from bus bits
    always_comb begin
        core_in_win     = (core_addr[ADDR_W-1:OFS_W] == WIN_TAG);
        bus_in_win      = (bus_addr[ADDR_W-1:OFS_W] == WIN_TAG);
        mix_ofs         = bus_addr[OFS_W-1:0];
        unused_core_low = ^core_addr[OFS_W-1:0];
    end

    // one select line per register of the window
    for (genvar j = 0; j < N_REG; j++) begin : g_sel
        assign reg_sel[j] = rd && core_in_win && (mix_ofs == OFS_W'(j));
    end
endmodule

// File: rtl/pad_strobe.sv
// pad_strobe: output enable and clock-event generation for one joypad port.
// In run mode an event fires on the first cycle of a run of selecting
// cycles; in every-read mode on each selecting cycle. Sync active-low reset.
module pad_strobe
    import io_win_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic mode,
    output logic oe_n,
    output logic clk_evt
);
    logic sel_prev;

    // remember whether the previous cycle selected this port
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel;
    end

    // enable follows select; event per run or per cycle
    always_comb begin
        oe_n    = !sel;
        clk_evt = sel && ((mode == PAD_MODE_EVERY) || !sel_prev);
    end

    AST_RUN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel) && sel && mode == PAD_MODE_RUN) |-> !clk_evt); // R5

    AST_EVERY_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mode == PAD_MODE_EVERY) |-> clk_evt); // R6
endmodule

// File: rtl/io_conflict.sv
// io_conflict: flags a bus conflict when a readable internal register is
// selected while the DMA fetches from outside the window, and flags the
// status register override. Combinational.
module io_conflict #(
    parameter int unsigned N_REG    = 32,
    parameter int unsigned STAT_OFS = 21,
    parameter int unsigned PAD_BASE = 22,
    parameter int unsigned N_PAD    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REG-1:0] reg_sel,
    input  logic             dma_active,
    input  logic             bus_in_win,
    output logic             bus_conflict,
    output logic             stat_override
);
    logic [N_REG-1:0] drv_hit;

    // mark the registers that drive the data bus when read
    for (genvar j = 0; j < N_REG; j++) begin : g_rd
        localparam bit DRIVES = (j == STAT_OFS) ||
                                (j >= PAD_BASE && j < PAD_BASE + N_PAD);
        assign drv_hit[j] = reg_sel[j] && DRIVES;
    end

    // conflict and override decisions
    always_comb begin
        bus_conflict  = dma_active && !bus_in_win && (|drv_hit);
        stat_override = reg_sel[STAT_OFS];
    end

    AST_CONFLICT_NEEDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |-> (dma_active && (|reg_sel))); // R7

    AST_OVERRIDE_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_override |-> $onehot(reg_sel)); // R8
endmodule

// File: rtl/io_window_select.sv
// io_window_select: top of the mixed-address I/O select and joypad strobe.
// Assumes bus_addr carries the DMA address on DMA access cycles and the
// core address otherwise; register contents live elsewhere.
module io_window_select
    import io_win_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned OFS_W    = OFS_W_DEF,
    parameter int unsigned N_PAD    = N_PAD_DEF,
    parameter int unsigned STAT_OFS = STAT_OFS_DEF,
    parameter int unsigned PAD_BASE = PAD_BASE_DEF,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      core_addr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   rd,
    input  logic                   dma_active,
    input  logic                   pad_mode,
    output logic [(1<<OFS_W)-1:0]  reg_sel,
    output logic [N_PAD-1:0]       pad_oe_n,
    output logic [N_PAD-1:0]       pad_clk,
    output logic                   bus_conflict,
    output logic                   stat_override
);
    localparam int unsigned N_REG = 1 << OFS_W;

    logic bus_in_win;

    io_win_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)) i_decode (
        .core_addr (core_addr),
        .bus_addr  (bus_addr),
        .rd        (rd),
        .reg_sel   (reg_sel),
        .bus_in_win(bus_in_win)
    );

    for (genvar i = 0; i < N_PAD; i++) begin : g_pad
        pad_strobe i_strobe (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (reg_sel[PAD_BASE+i]),
            .mode   (pad_mode),
            .oe_n   (pad_oe_n[i]),
            .clk_evt(pad_clk[i])
        );

        AST_OE_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe_n[i] |-> reg_sel[PAD_BASE+i]); // R4
    end

    io_conflict #(.N_REG(N_REG), .STAT_OFS(STAT_OFS), .PAD_BASE(PAD_BASE),
                  .N_PAD(N_PAD)) i_conflict (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .dma_active   (dma_active),
        .bus_in_win   (bus_in_win),
        .bus_conflict (bus_conflict),
        .stat_override(stat_override)
    );

    AST_OUTSIDE_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (core_addr[ADDR_W-1:OFS_W] != WIN_BASE[ADDR_W-1:OFS_W]) |->
        (reg_sel == '0 && pad_clk == '0 && !bus_conflict && !stat_override)); // R2

    AST_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (reg_sel == '0 && (&pad_oe_n) && pad_clk == '0)); // R3

    AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel)); // R1
endmodule

// File: tb/test_io_window_select.sv
module test_io_window_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] core_addr = 16'h0;
    logic [15:0] bus_addr = 16'h0;
    logic        rd = 1'b0;
    logic        dma_active = 1'b0;
    logic        pad_mode = 1'b0;
    logic [31:0] reg_sel;
    logic [1:0]  pad_oe_n;
    logic [1:0]  pad_clk;
    logic        bus_conflict;
    logic        stat_override;

    always #2 clk = ~clk;  // 250 MHz

    io_window_select i_io_window_select (
        .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .bus_addr(bus_addr),
        .rd(rd), .dma_active(dma_active), .pad_mode(pad_mode),
        .reg_sel(reg_sel), .pad_oe_n(pad_oe_n), .pad_clk(pad_clk),
        .bus_conflict(bus_conflict), .stat_override(stat_override)
    );

    typedef struct packed {
        logic [31:0] sel;
        logic [1:0]  oen;
        logic [1:0]  pclk;
        logic        conf;
        logic        ovr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    logic [1:0] model_prev = 2'b00;
    bit    done = 1'b0;

    // driver: apply one cycle of stimulus and queue its expected outputs
    task automatic drive(input logic [15:0] ca, input logic [15:0] ba,
                         input logic r, input logic d, input logic m,
                         input string tag);
        exp_t e;
        logic inw;
        logic binw;
        logic [4:0] o;
        @(posedge clk);
        #1;
        core_addr = ca; bus_addr = ba; rd = r; dma_active = d; pad_mode = m;
        inw  = (ca[15:5] == 11'h200);
        binw = (ba[15:5] == 11'h200);
        o    = ba[4:0];
        e = '0;
        e.oen = 2'b11;
        if (r && inw) begin
            e.sel[o] = 1'b1;
            if (o == 5'h16) e.oen[0] = 1'b0;
            if (o == 5'h17) e.oen[1] = 1'b0;
            if (o == 5'h15) e.ovr = 1'b1;
            if (d && !binw && o >= 5'h15 && o <= 5'h17) e.conf = 1'b1;
        end
        for (int i = 0; i < 2; i++)
            e.pclk[i] = !e.oen[i] && (m || !model_prev[i]);
        model_prev = rst_n ? ~e.oen : 2'b00;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare each queued expectation mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {reg_sel, pad_oe_n, pad_clk, bus_conflict, stat_override};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual sel=%h oe_n=%b clk=%b conf=%b ovr=%b expected sel=%h oe_n=%b clk=%b conf=%b ovr=%b",
                         t, a.sel, a.oen, a.pclk, a.conf, a.ovr,
                         e.sel, e.oen, e.pclk, e.conf, e.ovr);
            end
        end
    end

    initial begin
        // R10: reset held, idle bus
        for (int k = 0; k < 3; k++) drive(16'h4016, 16'h4016, 0, 0, 0, "R10 reset idle");
        rst_n = 1'b1;
        drive(16'h4016, 16'h4016, 1, 0, 0, "R10 first read after reset");
        drive(16'h4016, 16'h4016, 1, 0, 0, "R5 repeated stall read, no event");
        drive(16'h4016, 16'hC012, 1, 1, 0, "R1 DMA low bits select offset 0x12");
        drive(16'h4016, 16'h4016, 1, 0, 0, "R5 run restarts after DMA fetch");
        drive(16'h4016, 16'h8017, 1, 1, 0, "R9 other port clocked via DMA address");
        drive(16'h4016, 16'h8015, 1, 1, 0, "R8 status override with conflict");
        drive(16'h4016, 16'h4017, 1, 1, 0, "R7 no conflict inside window");
        drive(16'h4016, 16'h4017, 1, 1, 0, "R5 same port adjacent cycle");
        drive(16'h4016, 16'h4016, 1, 0, 0, "R4 switch back to port 0");
        drive(16'h4016, 16'h4016, 0, 0, 0, "R3 no read cycle");
        drive(16'h8016, 16'h4016, 1, 1, 0, "R2 core outside window");
        drive(16'h4016, 16'h4016, 1, 0, 1, "R6 every-read cycle 1");
        drive(16'h4016, 16'h4016, 1, 0, 1, "R6 every-read cycle 2");
        drive(16'h4016, 16'h4016, 1, 0, 1, "R6 every-read cycle 3");
        drive(16'h4016, 16'h8016, 1, 1, 1, "R7 conflict on port 0");
        drive(16'h4010, 16'h4003, 1, 0, 0, "R1 write-only offset");
        drive(16'h401F, 16'h401F, 1, 0, 0, "R1 top offset");
        drive(16'h3FF6, 16'h4016, 1, 1, 0, "R2 just below window");
        drive(16'h4020, 16'h4016, 1, 1, 0, "R2 just above window");
        drive(16'h4016, 16'h4015, 1, 0, 0, "R8 status read without DMA");
        drive(16'h4016, 16'h4016, 1, 0, 0, "R5 new run after status read");
        drive(16'h4016, 16'h4016, 0, 0, 0, "R3 idle end");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule